// File: doc/BRIEF.md
# Prefetching Serial-Address ROM Emulator

This block stands in for a slow graphics ROM chip that keeps its own address counter and sits on an 8-bit CPU bus. The CPU never presents a memory address directly. It loads the internal counter through an address port, then reads bytes one after another through a data port. Each byte comes from an internal buffer that was filled ahead of time. After each read, the chip advances its counter and refills that buffer in the background.

All chip timing comes from a slow square-wave chip clock, which is far slower than the system clock. During an access the chip pulls READY low and lets it go after one chip clock period. The refill that follows takes two and a half more chip periods. The CPU has already been released by then. If the CPU comes back too early, it sees the old buffer contents.

Up to eight of these chips can share one set of ports. Each chip owns one 8K region of the 64K space, picked by a 3-bit identity. In each region, 6K bytes are populated and the top 2K return a filler value.

Top module: `srom_emu`

## Requirements
- R1: While `sel` is low, `ready` is 1 and `rdEn` is 0, including while a background refill is still running.
- R2: `ready` is 0 in the first cycle in which `sel` is seen high. It returns to 1 only after two chip-clock transitions (one full chip period), which is 4 to 16 system cycles with the bench's chip clock. It stays 1 until `sel` drops.
- R3: A write with `modeAddr`=1 and `dirRead`=0 loads the address counter one byte per access, in the order bits 15:8 and then bits 7:0. After the low byte, the byte at the new address is fetched into the buffer.
- R4: A read with `modeAddr`=1 and `dirRead`=1 returns the counter in the order bits 15:8 and then bits 7:0. Each such read goes through its own READY cycle.
- R5: A read with `modeAddr`=0 and `dirRead`=1 returns the buffered byte. When READY is released, bits 12:0 of the counter increment. The buffer is refilled from the new address five chip-clock transitions later.
- R6: The byte at region offset o (0 to 6143) is o[7:0] XOR ((o>>8)<<3 truncated to 8 bits) XOR 8'h5A.
- R7: For offsets 6144 to 8191, the byte is the bitwise OR of the R6 bytes at o-2048 and o-4096.
- R8: Counter increments wrap inside the 13-bit offset. Bits 15:13 are left unchanged, so 16'h3FFF becomes 16'h2000.
- R9: On a data read, `rdEn` is 1 during the access only when counter bits 15:13 equal `CHIP_ID`. On an address read, `rdEn` is always 1. `rdEn` is never 1 on a write.
- R10: A data read that starts before the refill ends returns the previous byte again. It still advances the counter and restarts the refill.
- R11: A write with `modeAddr`=0 changes neither the counter nor the buffered data.
- R12: After reset the counter is 0, the buffer holds the byte at offset 0, and the next address-port access targets the high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chipClk | input | 1 | Slow square-wave chip clock (synchronised inside) |
| sel | input | 1 | Chip select, active high, one access per high period |
| modeAddr | input | 1 | 1 = address port, 0 = data port |
| dirRead | input | 1 | 1 = read, 0 = write |
| wrData | input | 8 | Byte written by the CPU |
| rdData | output | 8 | Byte returned to the CPU, valid when `ready` is high |
| rdEn | output | 1 | The chip drives the data bus |
| ready | output | 1 | Wait control toward the CPU, 0 = wait |

## Verification
The bench targets the stale-read window. It reads twice with only one idle cycle between the reads, and expects the first byte to come back twice. It then expects the counter to have moved by two. A design that refilled before releasing READY, or that dropped the second advance, would return fresh data or sit one byte behind.

The bench also covers these corner cases:
- It loads an address whose identity bits belong to another chip. A design that ignored the identity would drive the bus.
- It reads at 16'h3FFF. A design that carried the increment into the identity bits would read back 16'h4000.
- It reads in the upper 2K. A design with the alias wrong would return raw contents there.
- It writes to the data port. A design that did not treat the array as read-only would show an altered counter or altered data.

// File: rtl/srom_pkg.sv
package srom_pkg;
  parameter int ADDR_W     = 16;
  parameter int OFF_W      = 13;
  parameter int POP_BYTES  = 6144;
  parameter int ALIAS_STEP = 2048;
  localparam int ID_W = ADDR_W - OFF_W;

  typedef struct packed {
    logic capture;
    logic capAddr;
    logic capRead;
    logic advance;
    logic fetchLoad;
  } ctrlStrobe_t;

  function automatic logic [7:0] rawByte(input logic [OFF_W-1:0] o);
    logic [7:0] hi;
    hi = 8'(o >> 8);
    return o[7:0] ^ (hi << 3) ^ 8'h5A;
  endfunction

  function automatic logic [7:0] romByte(input logic [OFF_W-1:0] o);
    if (32'(o) < POP_BYTES)
      return rawByte(o);
    return rawByte(o - OFF_W'(ALIAS_STEP)) | rawByte(o - OFF_W'(2 * ALIAS_STEP));
  endfunction
endpackage

// File: rtl/srom_ctrl.sv
module srom_ctrl
  import srom_pkg::*;
#(
  parameter int READY_EDGES = 2,
  parameter int FETCH_EDGES = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        chipClk,
  input  logic        sel,
  input  logic        modeAddr,
  input  logic        dirRead,
  output ctrlStrobe_t strb,
  output logic        readyInt,
  output logic        accActive
);
  localparam int RW = $clog2(READY_EDGES + 1);
  localparam int CW = $clog2(FETCH_EDGES + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_HOLD} phase_t;

  phase_t        phase;
  logic [2:0]    ckSync;
  logic          selPrev;
  logic [RW-1:0] edgeCnt;
  logic [CW-1:0] fetchCnt;
  logic          kAddr, kRead;
  logic          chipEdge, startAcc, relFire, refetch;

  assign chipEdge  = ckSync[2] ^ ckSync[1];
  assign startAcc  = sel && !selPrev && (phase == PH_IDLE);
  assign relFire   = (phase == PH_WAIT) && sel && chipEdge && (edgeCnt == RW'(READY_EDGES - 1));
  assign refetch   = kAddr ? !kRead : kRead;
  assign readyInt  = (phase == PH_HOLD);
  assign accActive = (phase != PH_IDLE);

  always_comb begin
    strb.capture   = startAcc;
    strb.capAddr   = modeAddr;
    strb.capRead   = dirRead;
    strb.advance   = relFire && !kAddr && kRead;
    strb.fetchLoad = chipEdge && (fetchCnt == CW'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ckSync   <= '0;
      selPrev  <= 1'b0;
      phase    <= PH_IDLE;
      edgeCnt  <= '0;
      kAddr    <= 1'b0;
      kRead    <= 1'b0;
      fetchCnt <= '0;
    end else begin
      ckSync  <= {ckSync[1:0], chipClk};
      selPrev <= sel;
      case (phase)
        PH_IDLE: if (startAcc) begin
          phase   <= PH_WAIT;
          edgeCnt <= '0;
          kAddr   <= modeAddr;
          kRead   <= dirRead;
        end
        PH_WAIT: begin
          if (!sel)          phase   <= PH_IDLE;
          else if (relFire)  phase   <= PH_HOLD;
          else if (chipEdge) edgeCnt <= edgeCnt + RW'(1);
        end
        PH_HOLD: if (!sel) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
      if (relFire && refetch)
        fetchCnt <= CW'(FETCH_EDGES);
      else if (chipEdge && fetchCnt != '0)
        fetchCnt <= fetchCnt - CW'(1);
    end
  end

  // R2: wait state is asserted as soon as a new select is seen
  assert_ready_low_on_select_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sel) |-> !readyInt);

  // R2: once released, ready stays up for as long as select is held
  assert_ready_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    (readyInt && sel) |=> (readyInt || !$past(sel) || !sel));
endmodule

// File: rtl/srom_dp.sv
module srom_dp
  import srom_pkg::*;
#(
  parameter int CHIP_ID = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [7:0]        wrData,
  output logic [7:0]        outByte,
  output logic              driveOk
);
  logic [ADDR_W-1:0] addr;
  logic              loNext;
  logic [7:0]        buffer;
  logic              idMatch;

  assign idMatch = (addr[ADDR_W-1:OFF_W] == ID_W'(CHIP_ID));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr    <= '0;
      loNext  <= 1'b0;
      buffer  <= romByte('0);
      outByte <= '0;
      driveOk <= 1'b0;
    end else begin
      if (strb.capture) begin
        case ({strb.capAddr, strb.capRead})
          2'b10: begin
            if (loNext) addr[7:0]        <= wrData;
            else        addr[ADDR_W-1:8] <= wrData;
            loNext  <= !loNext;
            driveOk <= 1'b0;
          end
          2'b11: begin
            outByte <= loNext ? addr[7:0] : addr[ADDR_W-1:8];
            loNext  <= !loNext;
            driveOk <= 1'b1;
          end
          2'b01: begin
            outByte <= buffer;
            driveOk <= idMatch;
            loNext  <= 1'b0;
          end
          default: begin
            loNext  <= 1'b0;
            driveOk <= 1'b0;
          end
        endcase
      end
      if (strb.advance)
        addr[OFF_W-1:0] <= addr[OFF_W-1:0] + OFF_W'(1);
      if (strb.fetchLoad)
        buffer <= romByte(addr[OFF_W-1:0]);
    end
  end

  // R5: an advance moves the offset by exactly one
  assert_advance_by_one_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> (addr[OFF_W-1:0] == $past(addr[OFF_W-1:0]) + OFF_W'(1)));

  // R8: identity bits survive any increment, including the wrap
  assert_id_bits_kept_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> $stable(addr[ADDR_W-1:OFF_W]));
endmodule

// File: rtl/srom_emu.sv
module srom_emu
  import srom_pkg::*;
#(
  parameter int CHIP_ID     = 0,
  parameter int READY_EDGES = 2,
  parameter int FETCH_EDGES = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       chipClk,
  input  logic       sel,
  input  logic       modeAddr,
  input  logic       dirRead,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       rdEn,
  output logic       ready
);
  ctrlStrobe_t strb;
  logic        readyInt, accActive, driveOk;

  srom_ctrl #(.READY_EDGES(READY_EDGES), .FETCH_EDGES(FETCH_EDGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .chipClk(chipClk), .sel(sel),
    .modeAddr(modeAddr), .dirRead(dirRead),
    .strb(strb), .readyInt(readyInt), .accActive(accActive)
  );

  srom_dp #(.CHIP_ID(CHIP_ID)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .outByte(rdData), .driveOk(driveOk)
  );

  assign rdEn  = sel && accActive && driveOk;
  assign ready = sel ? readyInt : 1'b1;

  // R1: nothing reaches the bus without select
  assert_released_without_select_R1: assert property (@(posedge clk) disable iff (!rstN)
    !sel |-> (ready && !rdEn));

  // R9: the bus is only driven on reads
  assert_drive_only_on_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> dirRead);
endmodule

// File: tb/test_srom_emu.sv
module test_srom_emu;
  logic       clk = 0, rstN = 0, chipClk = 0;
  logic       sel = 0, modeAddr = 0, dirRead = 0;
  logic [7:0] wrData = 0;
  logic [7:0] rdData;
  logic       rdEn, ready;

  always #5  clk = ~clk;
  always #40 chipClk = ~chipClk;

  srom_emu #(.CHIP_ID(1)) i_srom_emu (
    .clk(clk), .rstN(rstN), .chipClk(chipClk), .sel(sel), .modeAddr(modeAddr),
    .dirRead(dirRead), .wrData(wrData), .rdData(rdData), .rdEn(rdEn), .ready(ready)
  );

  int    checks = 0, fails = 0;
  string expTag[$];
  int    expVal[$];
  int    actVal[$];

  function automatic int rawRef(int o);
    return (o & 8'hFF) ^ (((o >> 8) << 3) & 8'hFF) ^ 8'h5A;
  endfunction
  function automatic int romRef(int o);
    if (o < 6144) return rawRef(o);
    return rawRef(o - 2048) | rawRef(o - 4096);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    while (actVal.size() > 0 && expVal.size() > 0)
      chk(expTag.pop_front(), actVal.pop_front(), expVal.pop_front());
  end

  task automatic acc(bit isAddr, bit rd, logic [7:0] w, output logic [7:0] got, output bit drove);
    int lat;
    @(negedge clk);
    sel = 1; modeAddr = isAddr; dirRead = rd; wrData = w;
    @(negedge clk);
    chk("R2 ready low on select", ready, 0);
    lat = 1;
    while (!ready) begin @(negedge clk); lat++; end
    chk("R2 wait length in range", (lat >= 4 && lat <= 16), 1);
    got = rdData; drove = rdEn;
    sel = 0;
    @(negedge clk);
    chk("R1 released after select drop", {ready, rdEn}, 2'b10);
  endtask

  task automatic gap(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setAddr(int a);
    logic [7:0] g; bit d;
    acc(1, 0, 8'(a >> 8), g, d);
    chk("R9 no drive on address write", d, 0);
    gap(2);
    acc(1, 0, 8'(a), g, d);
    gap(40);
  endtask

  task automatic readData(string tag, int exp, int expDrive, int settle);
    logic [7:0] g; bit d;
    expTag.push_back(tag); expVal.push_back(exp);
    acc(0, 1, 8'h00, g, d);
    actVal.push_back(int'(g));
    chk({tag, " R9 drive"}, d, expDrive);
    gap(settle);
  endtask

  task automatic readAddr(string tag, int exp);
    logic [7:0] hi, lo; bit d1, d2;
    expTag.push_back(tag); expVal.push_back(exp);
    acc(1, 1, 8'h00, hi, d1);
    gap(2);
    acc(1, 1, 8'h00, lo, d2);
    actVal.push_back({hi, lo});
    chk("R9 address read driven", {d1, d2}, 2'b11);
    gap(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    logic [7:0] g; bit d;
    gap(3);
    chk("R1 reset ready released", ready, 1);
    chk("R1 reset not driving", rdEn, 0);
    rstN = 1;
    gap(3);
    readAddr("R12 reset counter", 16'h0000);
    readData("R12 reset buffer byte 0", romRef(0), 0, 40);

    setAddr(16'h2010);                                      // R3 load
    readData("R3 R6 first byte", romRef(16'h10), 1, 40);
    readData("R5 sequential", romRef(16'h11), 1, 40);
    readData("R5 sequential 2", romRef(16'h12), 1, 40);
    readAddr("R4 counter readback", 16'h2013);

    setAddr(16'h3900);
    readData("R7 filler top region", romRef(16'h1900), 1, 40);

    setAddr(16'h3FFF);
    readData("R7 filler last byte", romRef(16'h1FFF), 1, 40);
    readAddr("R8 wrap within region", 16'h2000);

    setAddr(16'h4000);
    readData("R9 other id not driven", romRef(0), 0, 40);
    readAddr("R9 counter advanced anyway", 16'h4001);

    setAddr(16'h2020);
    readData("R10 first read", romRef(16'h20), 1, 1);
    readData("R10 early read stale", romRef(16'h20), 1, 40);
    readData("R10 after settle", romRef(16'h22), 1, 40);

    setAddr(16'h2030);
    acc(0, 0, 8'hFF, g, d);
    chk("R11 no drive on data write", d, 0);
    gap(40);
    readAddr("R11 counter unchanged", 16'h2030);
    readData("R11 data unchanged", romRef(16'h30), 1, 10);

    gap(5);
    chk("R5 scoreboard drained", expVal.size() + actVal.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule